// File: doc/BRIEF.md
# Fixed-Point Biquad Section with Error Feedback

This block is a single second-order recursive filter section for a fixed-point low-pass cascade. Each cycle in which `x_valid` is high, it takes one signed sample, computes one output sample and raises `y_valid` on the next cycle. Four words of history are kept: two past inputs and two past outputs. The five coefficients are signed fixed-point parameters with `CF` fractional bits. The sum of products is formed in an accumulator wide enough that no product or partial sum is ever rounded or wrapped.

The output word is taken by dropping the accumulator's `CF` low-order bits, with no rounding step. The dropped fraction is not lost. The full-width accumulator of the previous sample is kept, and its residue is added into the next sum, which gives first-order shaping of the truncation error. The feedback coefficient applied to the truncated previous output is raised by one to balance this addition. A second pole mode is meant for sections whose poles sit close to z = 1. In that mode the first and second feedback coefficients are offset by +2 and −1, and the residues of both past outputs are fed back as 2·r1 − r2. If the truncated result falls outside the output word, it is clamped, and the stored residue is then cleared.

Top module: `biquad_df1_fs`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `y_out` is 0 and `y_valid` is 0. All history is cleared, so the first sample after reset is processed as if every past input, output and residue were zero.
- R2: `y_valid` is high exactly in the cycle after a cycle in which `x_valid` was high, and low in every other cycle.
- R3: In plain pole mode, the sum is A = b0·x[n] + b1·x[n−1] + b2·x[n−2] − a1·y[n−1] − a2·y[n−2] + r1. Here the coefficients are integers scaled by 2^CF, the y terms are past output words, and r1 is the previous full-width sum minus y[n−1]·2^CF. The output is y[n] = floor(A / 2^CF).
- R4: The output is obtained by truncation toward minus infinity, not by rounding. After every sample the stored residue lies in [0, 2^CF).
- R5: If floor(A / 2^CF) exceeds 2^(DW−1)−1 or falls below −2^(DW−1), the output is clamped to that limit and the stored residue becomes zero.
- R6: In near-DC pole mode, the sum is the same as in R3 except that the residue term is 2·r1 − r2, where r2 is the residue belonging to y[n−2].
- R7: A cycle with `x_valid` low changes neither `y_out` nor any history. The next valid sample gives the same result it would give with no idle cycles in between.
- R8: Full-scale inputs of either sign, alternated, produce results equal to the exact integer arithmetic of R3, R5 and R6, with no internal wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | DW | Input sample, two's complement |
| x_valid | input | 1 | Marks `x_in` as a new sample this cycle |
| y_out | output | DW | Filtered sample, two's complement, held between samples |
| y_valid | output | 1 | High for one cycle when `y_out` carries a new sample |

## Verification
Every result is due one cycle after the input that causes it. The sample is captured on the rising edge at which `x_valid` is seen, and `y_out` and `y_valid` change on that same edge. The bench drives inputs on the falling edge and samples the outputs 1 ns after the capturing rising edge, so each check sees exactly one new sample and never an edge in progress. On idle cycles the same sampling point confirms that the output held its value. A bench model keeps its own history, written in terms of the residue rather than offset coefficients. It steps only on valid cycles and is compared against three instances: plain, near-DC and high-gain.

// File: rtl/biq_pkg.sv
package biq_pkg;

  typedef enum logic [0:0] {
    POLE_PLAIN   = 1'b0,
    POLE_NEAR_DC = 1'b1
  } pole_mode_e;

  // Integer offset added to the first feedback coefficient so that the
  // full-width history terms can be accumulated exactly.
  function automatic int fb_offset_a1(input pole_mode_e m);
    return (m == POLE_NEAR_DC) ? 2 : 1;
  endfunction

  // Integer offset added to the second feedback coefficient.
  function automatic int fb_offset_a2(input pole_mode_e m);
    return (m == POLE_NEAR_DC) ? -1 : 0;
  endfunction

endpackage

// File: rtl/biq_mac.sv
module biq_mac #(
  parameter int DW      = 16,
  parameter int KW      = 19,
  parameter int ACCW    = 38,
  parameter bit NEAR_DC = 1'b0,
  parameter logic signed [KW-1:0] K_B0 = '0,
  parameter logic signed [KW-1:0] K_B1 = '0,
  parameter logic signed [KW-1:0] K_B2 = '0,
  parameter logic signed [KW-1:0] K_A1 = '0,
  parameter logic signed [KW-1:0] K_A2 = '0
) (
  input  logic signed [DW-1:0]   x0,
  input  logic signed [DW-1:0]   x1,
  input  logic signed [DW-1:0]   x2,
  input  logic signed [DW-1:0]   y1,
  input  logic signed [DW-1:0]   y2,
  input  logic signed [ACCW-1:0] f1,
  input  logic signed [ACCW-1:0] f2,
  output logic signed [ACCW-1:0] acc
);

  // Exact product: both operands sign-extended to the accumulator width.
  function automatic logic signed [ACCW-1:0] mulx(
    input logic signed [DW-1:0] s,
    input logic signed [KW-1:0] c
  );
    logic signed [ACCW-1:0] se;
    logic signed [ACCW-1:0] ce;
    se = ACCW'(s);
    ce = ACCW'(c);
    return se * ce;
  endfunction

  logic signed [ACCW-1:0] fwd_sum;
  logic signed [ACCW-1:0] fbk_sum;
  logic signed [ACCW-1:0] wide_hist;

  always_comb begin
    fwd_sum   = mulx(x0, K_B0) + mulx(x1, K_B1) + mulx(x2, K_B2);
    fbk_sum   = mulx(y1, K_A1) + mulx(y2, K_A2);
    wide_hist = NEAR_DC ? ((f1 <<< 1) - f2) : f1;
    acc       = fwd_sum - fbk_sum + wide_hist;
  end

endmodule

// File: rtl/biq_quant.sv
module biq_quant #(
  parameter int DW   = 16,
  parameter int CF   = 15,
  parameter int ACCW = 38
) (
  input  logic signed [ACCW-1:0] acc,
  output logic signed [DW-1:0]   y_word,
  output logic signed [ACCW-1:0] full_next,
  output logic                   sat_hi,
  output logic                   sat_lo
);

  localparam logic signed [ACCW-1:0] Y_MAX = ACCW'((2 ** (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] Y_MIN = ACCW'(-(2 ** (DW - 1)));

  logic signed [ACCW-1:0] y_trunc;
  logic signed [DW-1:0]   y_c;

  always_comb begin
    y_trunc = acc >>> CF;
    sat_hi  = (y_trunc > Y_MAX);
    sat_lo  = (y_trunc < Y_MIN);
    if (sat_hi)      y_c = Y_MAX[DW-1:0];
    else if (sat_lo) y_c = Y_MIN[DW-1:0];
    else             y_c = y_trunc[DW-1:0];
    y_word    = y_c;
    full_next = (sat_hi || sat_lo) ? (ACCW'(y_c) <<< CF) : acc;
  end

endmodule

// File: rtl/biq_hist.sv
module biq_hist #(
  parameter int DW   = 16,
  parameter int CF   = 15,
  parameter int ACCW = 38
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic signed [DW-1:0]   x_new,
  input  logic signed [DW-1:0]   y_new,
  input  logic signed [ACCW-1:0] f_new,
  output logic signed [DW-1:0]   x1,
  output logic signed [DW-1:0]   x2,
  output logic signed [DW-1:0]   y1,
  output logic signed [DW-1:0]   y2,
  output logic signed [ACCW-1:0] f1,
  output logic signed [ACCW-1:0] f2
);

  localparam logic signed [ACCW-1:0] ONE_WORD = ACCW'(2 ** CF);

  always_ff @(posedge clk) begin
    if (rst) begin
      x1 <= '0;
      x2 <= '0;
      y1 <= '0;
      y2 <= '0;
      f1 <= '0;
      f2 <= '0;
    end else if (load) begin
      x2 <= x1;
      x1 <= x_new;
      y2 <= y1;
      y1 <= y_new;
      f2 <= f1;
      f1 <= f_new;
    end
  end

  // Residue between stored full-width output and stored output word.
  logic signed [ACCW-1:0] residue1;
  assign residue1 = f1 - (ACCW'(y1) <<< CF);

  AST_RESIDUE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (residue1 >= '0) && (residue1 < ONE_WORD)); // R4

endmodule

// File: rtl/biquad_df1_fs.sv
module biquad_df1_fs #(
  parameter int DW = 16,
  parameter int CW = 17,
  parameter int CF = 15,
  parameter biq_pkg::pole_mode_e POLE_MODE = biq_pkg::POLE_PLAIN,
  parameter logic signed [CW-1:0] B0 = 17'sd2048,
  parameter logic signed [CW-1:0] B1 = 17'sd4096,
  parameter logic signed [CW-1:0] B2 = 17'sd2048,
  parameter logic signed [CW-1:0] A1 = -17'sd32768,
  parameter logic signed [CW-1:0] A2 = 17'sd8192
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] x_in,
  input  logic          x_valid,
  output logic [DW-1:0] y_out,
  output logic          y_valid
);

  localparam int KW   = CW + 2;        // room for the +2 / -1 offsets
  localparam int ACCW = DW + KW + 3;   // five products plus two wide terms
  localparam bit NEAR = (POLE_MODE == biq_pkg::POLE_NEAR_DC);

  localparam logic signed [KW-1:0] K_B0 = KW'(B0);
  localparam logic signed [KW-1:0] K_B1 = KW'(B1);
  localparam logic signed [KW-1:0] K_B2 = KW'(B2);
  localparam logic signed [KW-1:0] K_A1 =
    KW'(A1) + KW'(biq_pkg::fb_offset_a1(POLE_MODE) * (2 ** CF));
  localparam logic signed [KW-1:0] K_A2 =
    KW'(A2) + KW'(biq_pkg::fb_offset_a2(POLE_MODE) * (2 ** CF));

  localparam logic [DW-1:0] OUT_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] OUT_MIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0]   xs;
  logic signed [DW-1:0]   hx1, hx2, hy1, hy2;
  logic signed [ACCW-1:0] hf1, hf2;
  logic signed [ACCW-1:0] acc;
  logic signed [DW-1:0]   y_word;
  logic signed [ACCW-1:0] full_next;
  logic                   sat_hi;   // event: this sample clamps high
  logic                   sat_lo;   // event: this sample clamps low

  assign xs = x_in;

  biq_mac #(
    .DW(DW), .KW(KW), .ACCW(ACCW), .NEAR_DC(NEAR),
    .K_B0(K_B0), .K_B1(K_B1), .K_B2(K_B2), .K_A1(K_A1), .K_A2(K_A2)
  ) u_mac (
    .x0(xs), .x1(hx1), .x2(hx2), .y1(hy1), .y2(hy2),
    .f1(hf1), .f2(hf2), .acc(acc)
  );

  biq_quant #(.DW(DW), .CF(CF), .ACCW(ACCW)) u_quant (
    .acc(acc), .y_word(y_word), .full_next(full_next),
    .sat_hi(sat_hi), .sat_lo(sat_lo)
  );

  biq_hist #(.DW(DW), .CF(CF), .ACCW(ACCW)) u_hist (
    .clk(clk), .rst(rst), .load(x_valid),
    .x_new(xs), .y_new(y_word), .f_new(full_next),
    .x1(hx1), .x2(hx2), .y1(hy1), .y2(hy2), .f1(hf1), .f2(hf2)
  );

  always_ff @(posedge clk) begin
    if (rst) y_valid <= 1'b0;
    else     y_valid <= x_valid;
  end

  assign y_out = hy1;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    x_valid |=> y_valid); // R2
  AST_VALID_ONLY: assert property (@(posedge clk) disable iff (rst)
    !x_valid |=> !y_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !x_valid |=> $stable(y_out)); // R7
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (x_valid && sat_hi) |=> (y_out == OUT_MAX)); // R5
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (x_valid && sat_lo) |=> (y_out == OUT_MIN)); // R5

endmodule

// File: tb/biquad_df1_fs_tb.sv
`timescale 1ns/1ps
module biquad_df1_fs_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] x_in = '0;
  logic        x_vld = 1'b0;
  logic [15:0] y0, y1, y2;
  logic        v0, v1, v2;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  biquad_df1_fs u_dut (
    .clk(clk), .rst(rst), .x_in(x_in), .x_valid(x_vld),
    .y_out(y0), .y_valid(v0));

  biquad_df1_fs #(
    .POLE_MODE(biq_pkg::POLE_NEAR_DC),
    .B0(17'sd128), .B1(17'sd256), .B2(17'sd128),
    .A1(-17'sd61440), .A2(17'sd29184)
  ) u_dut_dc (
    .clk(clk), .rst(rst), .x_in(x_in), .x_valid(x_vld),
    .y_out(y1), .y_valid(v1));

  biquad_df1_fs #(
    .B0(17'sd49152), .B1(17'sd0), .B2(17'sd0), .A1(17'sd0), .A2(17'sd0)
  ) u_dut_sat (
    .clk(clk), .rst(rst), .x_in(x_in), .x_valid(x_vld),
    .y_out(y2), .y_valid(v2));

  // Bench model, one column per instance: plain, near-DC, high-gain.
  localparam longint CB0 [3] = '{2048, 128, 49152};
  localparam longint CB1 [3] = '{4096, 256, 0};
  localparam longint CB2 [3] = '{2048, 128, 0};
  localparam longint CA1 [3] = '{-32768, -61440, 0};
  localparam longint CA2 [3] = '{8192, 29184, 0};
  localparam bit     NDC [3] = '{1'b0, 1'b1, 1'b0};

  localparam int NV = 16;
  localparam int     VX [NV] = '{1000, 0, 1000, 1000, -32768, 32767, -32768, 32767,
                                 0, 0, -5, -7, 20000, 20000, 12345, -1};
  localparam bit     VV [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

  longint mx1 [3], mx2 [3], my1 [3], my2 [3], mf1 [3], mf2 [3];

  task automatic model_clear();
    for (int k = 0; k < 3; k++) begin
      mx1[k] = 0; mx2[k] = 0; my1[k] = 0; my2[k] = 0; mf1[k] = 0; mf2[k] = 0;
    end
  endtask

  task automatic model_step(input int k, input longint x);
    longint r1, r2, a, yt, ys, fn;
    r1 = mf1[k] - my1[k] * 32768;
    r2 = mf2[k] - my2[k] * 32768;
    a  = CB0[k] * x + CB1[k] * mx1[k] + CB2[k] * mx2[k]
       - CA1[k] * my1[k] - CA2[k] * my2[k];
    a  = NDC[k] ? (a + 2 * r1 - r2) : (a + r1);
    yt = a >>> 15;
    if (yt > 32767)       begin ys = 32767;  fn = ys * 32768; end
    else if (yt < -32768) begin ys = -32768; fn = ys * 32768; end
    else                  begin ys = yt;     fn = a; end
    mx2[k] = mx1[k]; mx1[k] = x;
    my2[k] = my1[k]; my1[k] = ys;
    mf2[k] = mf1[k]; mf1[k] = fn;
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  // Drive one cycle, then sample 1 ns after the capturing edge.
  task automatic apply(input int x, input bit v);
    @(negedge clk);
    x_in  = x[15:0];
    x_vld = v;
    @(posedge clk);
    #1;
    if (v) for (int k = 0; k < 3; k++) model_step(k, longint'(x));
    check("R2 valid plain", longint'(v0), longint'(v));
    check("R2 valid near-dc", longint'(v1), longint'(v));
    check("R2 valid high-gain", longint'(v2), longint'(v));
    check(v ? "R3 R8 plain output" : "R7 idle hold plain", sx(y0), my1[0]);
    check(v ? "R6 R8 near-dc output" : "R7 idle hold near-dc", sx(y1), my1[1]);
    check(v ? "R5 R8 high-gain output" : "R7 idle hold high-gain", sx(y2), my1[2]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    x_vld = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset y plain", sx(y0), 0);
    check("R1 reset y high-gain", sx(y2), 0);
    check("R1 reset valid", longint'(v0 | v1 | v2), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 first cycle after reset valid", longint'(v0 | v1 | v2), 0);
    check("R1 first cycle after reset y", sx(y1), 0);
    model_clear();
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();

    // Table walk: impulses, gaps, full-scale alternation, small negatives.
    for (int i = 0; i < NV; i++) apply(VX[i], VV[i]);
    for (int i = 0; i < 40; i++) apply(3000, 1'b1);   // settle a DC step
    apply(0, 1'b0);
    apply(0, 1'b0);

    // Directed corner cases on the high-gain instance (gain 1.5, no poles).
    do_reset();
    apply(1, 1'b1);
    check("R4 truncation 1.5 -> 1", sx(y2), 1);
    apply(1, 1'b1);
    check("R3 residue carried 1.5+0.5 -> 2", sx(y2), 2);
    apply(-1, 1'b1);
    check("R4 truncation -1.5 -> -2", sx(y2), -2);
    apply(30000, 1'b1);
    check("R5 clamp high", sx(y2), 32767);
    apply(0, 1'b1);
    check("R5 residue cleared after clamp", sx(y2), 0);
    apply(-30000, 1'b1);
    check("R5 clamp low", sx(y2), -32768);
    apply(7, 1'b0);
    check("R7 idle input ignored", sx(y2), -32768);
    apply(2, 1'b1);
    check("R7 history unchanged by idle", sx(y2), 3);

    // Reset in the middle of activity clears all history.
    do_reset();
    apply(1, 1'b1);
    check("R1 history cleared by reset", sx(y2), 1);
    apply(-32768, 1'b1);
    apply(32767, 1'b1);
    apply(0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule